// File: doc/BRIEF.md
# Bit-Field Deposit Unit

This unit writes a right-justified value into a contiguous field of a 32-bit target word and returns the new word one clock later. Two independent choices select where the field sits and what is written into it. The field's lowest bit comes either from an immediate position field or from a shift-amount register. The written value comes either from a source register or from a 5-bit signed immediate that is sign-extended across the whole field.

The field width is given in complemented form: a 5-bit length code `clen` gives a width of 32 minus `clen`, so widths run from 1 to 32. A field that would run past bit 31 is cut off at the word edge. A merge flag decides what happens to the bits outside the field. With the flag set they keep the target word's bits. With the flag clear they are zero, so an immediate deposit with the flag clear produces a constant.

The unit is meant to sit in an execute stage, with register reads and condition handling done elsewhere.

Top module: `bfd_deposit_unit`

## Requirements
- R1: The field width is 32 minus `clen`, where `clen` is read as an unsigned 5-bit value. `clen` = 0 gives a 32-bit field.
- R2: When the field's lowest bit plus its width exceeds 32, only bits from the lowest bit up to bit 31 are written. Nothing wraps into the low bits.
- R3: With `merge_en` = 1, every result bit outside the field equals the corresponding bit of `target_in`.
- R4: With `merge_en` = 0, every result bit outside the field is 0.
- R5: When the value comes from the immediate, `imm5` is sign-extended from its bit 4 and the field's low bits receive it. An immediate of 5'b11111 fills a field of any width with ones, and 5'b01111 puts 1111 in the four lowest field bits and zeros in the rest of the field.
- R6: `mode` bit 0 selects the position source: 1 means `cpos`, 0 means the shift-amount input. `mode` bit 1 selects the value source: 0 means `src_in`, 1 means `imm5`.
- R7: In the shift-amount position modes, the field's lowest bit is 31 minus `sar`. Field bits that would lie above bit 31 are dropped.
- R8: After reset, `result` is 0 and `result_vld` is 0. `result_vld` is 1 in exactly the cycles that follow a cycle with `start` = 1. `result` changes only after a start and otherwise holds its value.
- R9: A 32-bit field at position 0 replaces the whole word with the value, whatever `merge_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a deposit for the operands presented in this cycle |
| mode | input | 2 | Bit 1: value source (0 register, 1 immediate). Bit 0: position source (0 shift amount, 1 immediate) |
| merge_en | input | 1 | 1 keeps target bits outside the field; 0 clears them |
| target_in | input | 32 | Current contents of the destination word |
| src_in | input | 32 | Register value to deposit |
| imm5 | input | 5 | Signed immediate value to deposit |
| cpos | input | 5 | Immediate position of the field's lowest bit |
| clen | input | 5 | Complemented field width (width = 32 - clen) |
| sar | input | 5 | Shift-amount register, numbered from the most significant bit |
| result | output | 32 | Deposited word |
| result_vld | output | 1 | High in the cycle after a start |

## Verification
A wrong field geometry shows up at the ports in the very next cycle. A mis-clipped or mis-placed mask either damages bits outside the field, which is visible against `target_in` when merging and as stray ones when zeroing, or it moves the value's low bits. A wrong value selection or sign extension appears inside the field, and is plainest with wide fields and negative immediates. Corner widths of 1 and 32, and positions near bit 31 and bit 0, expose wrap and boundary faults.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  parameter int unsigned BFD_W  = 32;
  parameter int unsigned BFD_PW = 5;
  parameter int unsigned BFD_IW = 5;

  typedef enum logic [1:0] {
    DEP_REG_AT_SAR = 2'b00,
    DEP_REG_AT_IMM = 2'b01,
    DEP_IMM_AT_SAR = 2'b10,
    DEP_IMM_AT_IMM = 2'b11
  } dep_mode_e;

  function automatic logic pos_from_imm(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic val_from_imm(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/bfd_geometry.sv
module bfd_geometry #(
  parameter int unsigned W  = bfd_pkg::BFD_W,
  parameter int unsigned PW = bfd_pkg::BFD_PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_imm_pos,
  input  logic [PW-1:0] cpos,
  input  logic [PW-1:0] sar,
  input  logic [PW-1:0] clen,
  output logic [PW-1:0] field_lsb,
  output logic [PW:0]   field_len,
  output logic [W-1:0]  field_mask
);
  localparam logic [PW-1:0] TOP_BIT = PW'(W - 1);
  localparam logic [PW:0]   FULL    = (PW + 1)'(W);

  logic [PW:0] len_raw;
  logic [PW:0] room;
  logic [PW:0] lsb_ext;
  logic [PW:0] end_ext;

  always_comb begin
    field_lsb = use_imm_pos ? cpos : (TOP_BIT - sar);
    lsb_ext   = {1'b0, field_lsb};
    len_raw   = FULL - {1'b0, clen};
    room      = FULL - lsb_ext;
    field_len = (len_raw > room) ? room : len_raw;
    end_ext   = lsb_ext + field_len;
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign field_mask[i] = (lsb_ext <= (PW + 1)'(i)) && ((PW + 1)'(i) < end_ext);
  end

  // R2: the clipped field never runs past the word edge
  a_r2_field_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_ext + field_len) <= FULL);
  // R1: mask population matches the clipped width
  a_r1_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(field_mask) == int'(field_len));
  // R1: field always contains its lowest bit
  a_r1_field_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    field_mask[field_lsb]);
endmodule

// File: rtl/bfd_value_sel.sv
module bfd_value_sel #(
  parameter int unsigned W  = bfd_pkg::BFD_W,
  parameter int unsigned IW = bfd_pkg::BFD_IW
) (
  input  logic          use_imm_val,
  input  logic [W-1:0]  src_in,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  dep_value
);
  logic [W-1:0] imm_ext;

  for (genvar i = 0; i < W; i++) begin : g_sext
    if (i < IW) begin : g_low
      assign imm_ext[i] = imm[i];
    end else begin : g_high
      assign imm_ext[i] = imm[IW-1];
    end
  end

  assign dep_value = use_imm_val ? imm_ext : src_in;
endmodule

// File: rtl/bfd_merge.sv
module bfd_merge #(
  parameter int unsigned W  = bfd_pkg::BFD_W,
  parameter int unsigned PW = bfd_pkg::BFD_PW
) (
  input  logic          merge_en,
  input  logic [W-1:0]  target_in,
  input  logic [W-1:0]  dep_value,
  input  logic [PW-1:0] field_lsb,
  input  logic [W-1:0]  field_mask,
  output logic [W-1:0]  merged
);
  logic [W-1:0] placed;
  logic [W-1:0] keep;

  always_comb begin
    placed = (dep_value << field_lsb) & field_mask;
    keep   = merge_en ? (target_in & ~field_mask) : '0;
    merged = keep | placed;
  end
endmodule

// File: rtl/bfd_deposit_unit.sv
module bfd_deposit_unit #(
  parameter int unsigned W  = bfd_pkg::BFD_W,
  parameter int unsigned PW = bfd_pkg::BFD_PW,
  parameter int unsigned IW = bfd_pkg::BFD_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          merge_en,
  input  logic [W-1:0]  target_in,
  input  logic [W-1:0]  src_in,
  input  logic [IW-1:0] imm5,
  input  logic [PW-1:0] cpos,
  input  logic [PW-1:0] clen,
  input  logic [PW-1:0] sar,
  output logic [W-1:0]  result,
  output logic          result_vld
);
  import bfd_pkg::*;

  logic          use_imm_pos;
  logic          use_imm_val;
  logic [PW-1:0] field_lsb;
  logic [PW:0]   field_len;
  logic [W-1:0]  field_mask;
  logic [W-1:0]  dep_value;
  logic [W-1:0]  merged;

  assign use_imm_pos = pos_from_imm(mode);
  assign use_imm_val = val_from_imm(mode);

  bfd_geometry #(.W(W), .PW(PW)) u_geom (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_imm_pos(use_imm_pos),
    .cpos       (cpos),
    .sar        (sar),
    .clen       (clen),
    .field_lsb  (field_lsb),
    .field_len  (field_len),
    .field_mask (field_mask)
  );

  bfd_value_sel #(.W(W), .IW(IW)) u_val (
    .use_imm_val(use_imm_val),
    .src_in     (src_in),
    .imm        (imm5),
    .dep_value  (dep_value)
  );

  bfd_merge #(.W(W), .PW(PW)) u_merge (
    .merge_en  (merge_en),
    .target_in (target_in),
    .dep_value (dep_value),
    .field_lsb (field_lsb),
    .field_mask(field_mask),
    .merged    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      result_vld <= start;
      if (start) result <= merged;
    end
  end

  // R8: valid strobe follows start by one cycle
  a_r8_vld_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_vld);
  a_r8_vld_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_vld);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  // R3: bits outside the field keep the target when merging
  a_r3_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && merge_en) |=> ((result & ~$past(field_mask)) == ($past(target_in) & ~$past(field_mask))));
  // R4: bits outside the field are cleared when not merging
  a_r4_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !merge_en) |=> ((result & ~$past(field_mask)) == '0));
endmodule

// File: tb/tb_bfd_deposit_unit.sv
module tb_bfd_deposit_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        merge_en = 1'b0;
  logic [31:0] target_in = '0;
  logic [31:0] src_in = '0;
  logic [4:0]  imm5 = '0;
  logic [4:0]  cpos = '0;
  logic [4:0]  clen = '0;
  logic [4:0]  sar = '0;
  logic [31:0] result;
  logic        result_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_res = '0;
  logic        exp_vld = 1'b0;
  string       exp_tag = "R8";

  always #5 clk = ~clk;

  bfd_deposit_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .merge_en(merge_en),
    .target_in(target_in), .src_in(src_in), .imm5(imm5), .cpos(cpos),
    .clen(clen), .sar(sar), .result(result), .result_vld(result_vld)
  );

  // Behavioural reference: bit by bit walk over the field
  function automatic logic [31:0] ref_deposit(
      input logic [1:0] m, input logic mg, input logic [31:0] tgt,
      input logic [31:0] src, input logic [4:0] im, input logic [4:0] cp,
      input logic [4:0] cl, input logic [4:0] sa);
    int len = 32 - int'(cl);
    int lo  = m[0] ? int'(cp) : (31 - int'(sa));
    logic [31:0] val;
    logic [31:0] out;
    if (m[1]) begin
      for (int k = 0; k < 32; k++) val[k] = (k < 5) ? im[k] : im[4];
    end else begin
      val = src;
    end
    out = mg ? tgt : 32'h0;
    for (int k = 0; k < len; k++) begin
      if (lo + k < 32) out[lo + k] = val[k];
    end
    return out;
  endfunction

  task automatic check_now();
    checks++;
    if (result_vld !== exp_vld || result !== exp_res) begin
      fails++;
      $display("FAIL %s: result=%08h vld=%0b expected result=%08h vld=%0b",
               exp_tag, result, result_vld, exp_res, exp_vld);
    end
  endtask

  // One cycle: check outputs of the previous step, then drive the next operands
  task automatic step(input string tag, input logic st, input logic [1:0] m,
                      input logic mg, input logic [31:0] tgt, input logic [31:0] src,
                      input logic [4:0] im, input logic [4:0] cp,
                      input logic [4:0] cl, input logic [4:0] sa);
    @(negedge clk);
    check_now();
    start = st; mode = m; merge_en = mg; target_in = tgt; src_in = src;
    imm5 = im; cpos = cp; clen = cl; sar = sa;
    exp_vld = st;
    exp_tag = tag;
    if (st) exp_res = ref_deposit(m, mg, tgt, src, im, cp, cl, sa);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    checks++;
    if (result !== 32'h0 || result_vld !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset result=%08h vld=%0b expected result=00000000 vld=0",
               result, result_vld);
    end
    rst_n = 1'b1;
    // R1 R4: width 8 at position 4, zero outside
    step("R1", 1, 2'b01, 0, 32'hFFFF_FFFF, 32'h0000_00AB, 5'd0, 5'd4, 5'd24, 5'd0);
    // R3: merge keeps target
    step("R3", 1, 2'b01, 1, 32'h1234_5678, 32'h0000_00AB, 5'd0, 5'd4, 5'd24, 5'd0);
    step("R4", 1, 2'b01, 0, 32'h1234_5678, 32'hFFFF_FFFF, 5'd0, 5'd12, 5'd20, 5'd0);
    // R2: clip at the word edge
    step("R2", 1, 2'b01, 1, 32'h0000_0000, 32'h0000_00FF, 5'd0, 5'd28, 5'd24, 5'd0);
    step("R2", 1, 2'b01, 0, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 5'd0, 5'd31, 5'd0, 5'd0);
    // R5: sign-extended immediate fills the field
    step("R5", 1, 2'b11, 0, 32'h0, 32'h0, 5'b11111, 5'd8, 5'd24, 5'd0);
    step("R5", 1, 2'b11, 1, 32'h5555_5555, 32'h0, 5'b01111, 5'd8, 5'd24, 5'd0);
    step("R5", 1, 2'b11, 0, 32'h0, 32'h0, 5'b10000, 5'd0, 5'd0, 5'd0);
    // R7: shift-amount position
    step("R7", 1, 2'b00, 0, 32'h0, 32'h0000_00F3, 5'd0, 5'd0, 5'd24, 5'd31);
    step("R7", 1, 2'b00, 1, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 5'd0, 5'd0, 5'd16, 5'd0);
    step("R7", 1, 2'b00, 0, 32'h0, 32'h0000_0FFF, 5'd0, 5'd0, 5'd20, 5'd7);
    // R6: immediate value at shift-amount position, register value ignored
    step("R6", 1, 2'b10, 1, 32'hDEAD_BEEF, 32'h0000_0000, 5'b10101, 5'd3, 5'd28, 5'd15);
    // R9: full word replacement
    step("R9", 1, 2'b01, 1, 32'hFFFF_FFFF, 32'hCAFE_F00D, 5'd0, 5'd0, 5'd0, 5'd0);
    step("R9", 1, 2'b00, 0, 32'hFFFF_FFFF, 32'h8765_4321, 5'd0, 5'd0, 5'd0, 5'd31);
    // R8: idle cycles hold result and drop valid
    step("R8", 0, 2'b11, 0, 32'h0, 32'h0, 5'b11111, 5'd0, 5'd0, 5'd0);
    step("R8", 0, 2'b01, 1, 32'h1111_1111, 32'h2222_2222, 5'd0, 5'd3, 5'd3, 5'd3);
    // R6: mixed random operands across all modes
    for (int n = 0; n < 300; n++) begin
      step("R6", ($urandom % 4) != 0, 2'($urandom), 1'($urandom), $urandom, $urandom,
           5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
    end
    step("R8", 0, 2'b00, 0, 32'h0, 32'h0, 5'd0, 5'd0, 5'd0, 5'd0);
    @(negedge clk);
    check_now();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8: watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule